// File: doc/BRIEF.md
# Hardware A20 Gate Interceptor

This block watches host write cycles into the input buffer of an 8-bit slave controller. After the controller core enables it, the block recognises the host's "write output port" command sequence on its own. That sequence is a D1h command followed by a data byte. The block copies one bit of that data byte straight to the A20 gate output, and the firmware plays no part in it. Writes that form part of a recognised sequence are consumed, so the input-buffer-full flag downstream is never raised for them. Every other write goes on to the normal input buffer path as a one-cycle delivery strobe, together with the byte and its command/data flag.

The host strobes are treated as level signals in the block's clock domain. A parameter can add synchroniser stages in front of the strobes. A write is taken at the trailing (rising) edge of the active-low write strobe, and only if chip select was asserted while the strobe was low. A0 high marks a command byte and A0 low marks a data byte.

Top module: `a20_gate_intercept`

## Requirements
- R1: After reset, `a20_o` is 0, `dlv_vld_o` is 0 and the interception logic is disabled.
- R2: While disabled, every selected write is delivered unchanged, with its byte and A0 value, and this includes D1h commands. A20 stays as it is.
- R3: A one-cycle pulse on `en_req_i` enables the logic, and it then stays enabled until reset. A D1h command delivered before the pulse is absorbed after it.
- R4: A write whose chip select (`cs_n_i`) is high during the strobe produces no delivery and no change to A20.
- R5: Once enabled, a command write (A0=1) of value D1h is absorbed, so `dlv_vld_o` stays 0, and it arms the sequence.
- R6: A data write (A0=0) that follows an armed sequence is absorbed. `a20_o` takes the value of data bit 1 and ignores all other bits: DFh gives 1, DDh gives 0, 02h gives 1, FDh gives 0.
- R7: Two D1h commands in a row before the data byte are both absorbed, and the data byte that follows still updates A20 and is absorbed.
- R8: An FFh command written right after a completed sequence is absorbed. An FFh command written at any other time is delivered.
- R9: Any command other than D1h written while armed cancels the sequence and is itself delivered. A data write after it is delivered and leaves A20 unchanged.
- R10: A data write outside an armed sequence is delivered and never changes `a20_o`.
- R11: A delivery appears as a single-cycle `dlv_vld_o` pulse in the cycle after the clock edge that sees the strobe's trailing edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req_i | input | 1 | One-cycle enable request from the controller core |
| wr_n_i | input | 1 | Host write strobe, active low |
| cs_n_i | input | 1 | Host chip select, active low |
| a0_i | input | 1 | Command (1) / data (0) select |
| data_i | input | 8 | Host data byte |
| a20_o | output | 1 | A20 gate level |
| dlv_vld_o | output | 1 | Deliver-to-input-buffer strobe |
| dlv_data_o | output | 8 | Byte delivered to the input buffer |
| dlv_a0_o | output | 1 | A0 value of the delivered byte |

## Verification
The first writes go in while the block is disabled, so that pass-through of a D1h command can be told apart from interception. The later writes go in after enabling. Set and clear sequences use data values that differ only in bit 1, and values whose other bits oppose bit 1, which shows that only bit 1 is used. Double-D1h, cancelled and trailing-FFh patterns each separate absorption from delivery, because the flag output differs between them while A20 may not change. A write made with chip select high and a second reset show that unselected writes are ignored and that the enable does not outlive reset.

// File: rtl/a20g_pkg.sv
package a20g_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_DONE  = 2'd2
  } a20g_state_e;
endpackage

// File: rtl/a20g_strobe.sv
module a20g_strobe #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n_i,
  input  logic              cs_n_i,
  input  logic              a0_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              evt_o,
  output logic              evt_a0_o,
  output logic [DATA_W-1:0] evt_data_o
);
  localparam bit USE_SYNC = (SYNC_STAGES > 0);

  logic wr_s, cs_s;

  generate
    if (USE_SYNC) begin : g_sync
      logic [SYNC_STAGES-1:0] wr_chain_q, cs_chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wr_chain_q <= '1;
          cs_chain_q <= '1;
        end else begin
          wr_chain_q <= {wr_chain_q[SYNC_STAGES-1:0], wr_n_i} >> 0;
          cs_chain_q <= {cs_chain_q[SYNC_STAGES-1:0], cs_n_i} >> 0;
        end
      end
      assign wr_s = wr_chain_q[SYNC_STAGES-1];
      assign cs_s = cs_chain_q[SYNC_STAGES-1];
    end else begin : g_direct
      assign wr_s = wr_n_i;
      assign cs_s = cs_n_i;
    end
  endgenerate

  logic              wr_q, wr_d;
  logic              sel_q, sel_d;
  logic              a0_q, a0_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              cap_en;

  // capture while the strobe is low; latest values win
  always_comb begin
    cap_en = ~wr_s;
    wr_d   = wr_s;
    sel_d  = sel_q;
    a0_d   = a0_q;
    dat_d  = dat_q;
    if (cap_en) begin
      sel_d = ~cs_s;
      a0_d  = a0_i;
      dat_d = data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b1;
      sel_q <= 1'b0;
      a0_q  <= 1'b0;
      dat_q <= '0;
    end else begin
      wr_q  <= wr_d;
      sel_q <= sel_d;
      a0_q  <= a0_d;
      dat_q <= dat_d;
    end
  end

  assign evt_o      = wr_s & ~wr_q & sel_q;
  assign evt_a0_o   = a0_q;
  assign evt_data_o = dat_q;

  // event can only follow a low strobe cycle
  assert_evt_after_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> $past(~wr_s));
endmodule

// File: rtl/a20g_seq.sv
module a20g_seq
  import a20g_pkg::*;
#(
  parameter int              DATA_W   = 8,
  parameter logic [DATA_W-1:0] CMD_ARM  = 8'hD1,
  parameter logic [DATA_W-1:0] CMD_TAIL = 8'hFF,
  parameter int              GATE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_req_i,
  input  logic              evt_i,
  input  logic              evt_a0_i,
  input  logic [DATA_W-1:0] evt_data_i,
  output logic              enabled_o,
  output logic              pass_o,
  output logic              gate_we_o,
  output logic              gate_d_o
);
  localparam int GB = (GATE_BIT < DATA_W) ? GATE_BIT : 0;

  a20g_state_e state_q, state_d;
  logic        en_q, en_d;
  logic        is_arm, is_tail;

  always_comb begin
    is_arm    = (evt_data_i == CMD_ARM);
    is_tail   = (evt_data_i == CMD_TAIL);
    state_d   = state_q;
    en_d      = en_q | en_req_i;
    pass_o    = 1'b0;
    gate_we_o = 1'b0;
    gate_d_o  = evt_data_i[GB];
    if (evt_i) begin
      if (!en_q) begin
        pass_o  = 1'b1;
        state_d = SEQ_IDLE;
      end else if (evt_a0_i) begin
        if (is_arm) begin
          state_d = SEQ_ARMED;
        end else if (is_tail && state_q == SEQ_DONE) begin
          state_d = SEQ_IDLE;
        end else begin
          pass_o  = 1'b1;
          state_d = SEQ_IDLE;
        end
      end else begin
        if (state_q == SEQ_ARMED) begin
          gate_we_o = 1'b1;
          state_d   = SEQ_DONE;
        end else begin
          pass_o  = 1'b1;
          state_d = SEQ_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      en_q    <= en_d;
    end
  end

  assign enabled_o = en_q;

  assert_enable_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);

  assert_cancel_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_ARMED && evt_i && evt_a0_i && !is_arm) |=> state_q == SEQ_IDLE);

  assert_disabled_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> state_q == SEQ_IDLE);
endmodule

// File: rtl/a20g_outreg.sv
module a20g_outreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pass_i,
  input  logic              evt_a0_i,
  input  logic [DATA_W-1:0] evt_data_i,
  input  logic              gate_we_i,
  input  logic              gate_d_i,
  output logic              a20_o,
  output logic              vld_o,
  output logic              a0_o,
  output logic [DATA_W-1:0] data_o
);
  logic              a20_q, a20_d;
  logic              vld_q, vld_d;
  logic              a0_q, a0_d;
  logic [DATA_W-1:0] dat_q, dat_d;

  always_comb begin
    a20_d = a20_q;
    if (gate_we_i) a20_d = gate_d_i;
    vld_d = pass_i;
    a0_d  = a0_q;
    dat_d = dat_q;
    if (pass_i) begin
      a0_d  = evt_a0_i;
      dat_d = evt_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a20_q <= 1'b0;
      vld_q <= 1'b0;
      a0_q  <= 1'b0;
      dat_q <= '0;
    end else begin
      a20_q <= a20_d;
      vld_q <= vld_d;
      a0_q  <= a0_d;
      dat_q <= dat_d;
    end
  end

  assign a20_o  = a20_q;
  assign vld_o  = vld_q;
  assign a0_o   = a0_q;
  assign data_o = dat_q;

  assert_vld_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  assert_a20_only_by_seq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(a20_q) |-> $past(gate_we_i));
endmodule

// File: rtl/a20_gate_intercept.sv
module a20_gate_intercept #(
  parameter int                DATA_W      = 8,
  parameter logic [DATA_W-1:0] CMD_ARM     = 8'hD1,
  parameter logic [DATA_W-1:0] CMD_TAIL    = 8'hFF,
  parameter int                GATE_BIT    = 1,
  parameter int                SYNC_STAGES = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_req_i,
  input  logic              wr_n_i,
  input  logic              cs_n_i,
  input  logic              a0_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              a20_o,
  output logic              dlv_vld_o,
  output logic [DATA_W-1:0] dlv_data_o,
  output logic              dlv_a0_o
);
  logic              evt, evt_a0;
  logic [DATA_W-1:0] evt_data;
  logic              enabled, pass, gate_we, gate_d;

  a20g_strobe #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_strobe (
    .clk(clk), .rst_n(rst_n), .wr_n_i(wr_n_i), .cs_n_i(cs_n_i),
    .a0_i(a0_i), .data_i(data_i),
    .evt_o(evt), .evt_a0_o(evt_a0), .evt_data_o(evt_data)
  );

  a20g_seq #(.DATA_W(DATA_W), .CMD_ARM(CMD_ARM), .CMD_TAIL(CMD_TAIL),
             .GATE_BIT(GATE_BIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .en_req_i(en_req_i),
    .evt_i(evt), .evt_a0_i(evt_a0), .evt_data_i(evt_data),
    .enabled_o(enabled), .pass_o(pass), .gate_we_o(gate_we), .gate_d_o(gate_d)
  );

  a20g_outreg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .pass_i(pass), .evt_a0_i(evt_a0),
    .evt_data_i(evt_data), .gate_we_i(gate_we), .gate_d_i(gate_d),
    .a20_o(a20_o), .vld_o(dlv_vld_o), .a0_o(dlv_a0_o), .data_o(dlv_data_o)
  );

  assert_arm_absorbed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && enabled && evt_a0 && evt_data == CMD_ARM) |=> !dlv_vld_o);

  assert_disabled_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !enabled) |=> (dlv_vld_o && dlv_data_o == $past(evt_data)
                           && dlv_a0_o == $past(evt_a0)));
endmodule

// File: tb/tb_a20_gate_intercept.sv
`timescale 1ns/1ps
module tb_a20_gate_intercept;
  logic       clk, rst_n, en_req, wr_n, cs_n, a0;
  logic [7:0] data;
  logic       a20, vld, dlv_a0;
  logic [7:0] dlv_data;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic       o_vld, o_vld2, o_a0, o_a20;
  logic [7:0] o_data;

  a20_gate_intercept dut (
    .clk(clk), .rst_n(rst_n), .en_req_i(en_req), .wr_n_i(wr_n), .cs_n_i(cs_n),
    .a0_i(a0), .data_i(data), .a20_o(a20), .dlv_vld_o(vld),
    .dlv_data_o(dlv_data), .dlv_a0_o(dlv_a0)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp_v);
    n_run++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic host_wr(input logic a0_v, input logic [7:0] d, input logic cs_v);
    @(negedge clk);
    cs_n = ~cs_v; a0 = a0_v; data = d; wr_n = 0;
    @(negedge clk);
    @(negedge clk);
    wr_n = 1;
    @(posedge clk); #1;
    o_vld = vld; o_data = dlv_data; o_a0 = dlv_a0; o_a20 = a20;
    @(posedge clk); #1;
    o_vld2 = vld;
    @(negedge clk);
    cs_n = 1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; en_req = 0; wr_n = 1; cs_n = 1; a0 = 0; data = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic do_enable();
    @(negedge clk); en_req = 1;
    @(negedge clk); en_req = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 a20", {7'd0, a20}, 8'd0);
    chk("R1 vld", {7'd0, vld}, 8'd0);
  endtask

  task automatic t_disabled();
    host_wr(1, 8'hD1, 1);
    chk("R2 cmd vld", {7'd0, o_vld}, 8'd1);
    chk("R2 cmd data", o_data, 8'hD1);
    chk("R2 cmd a0", {7'd0, o_a0}, 8'd1);
    chk("R11 pulse one cycle", {7'd0, o_vld2}, 8'd0);
    host_wr(0, 8'hDF, 1);
    chk("R2 data vld", {7'd0, o_vld}, 8'd1);
    chk("R2 data a0", {7'd0, o_a0}, 8'd0);
    chk("R2 a20 kept", {7'd0, o_a20}, 8'd0);
  endtask

  task automatic t_nocs();
    host_wr(1, 8'h12, 0);
    chk("R4 no delivery", {7'd0, o_vld}, 8'd0);
    chk("R4 a20 kept", {7'd0, o_a20}, 8'd0);
  endtask

  task automatic t_set_clear();
    do_enable();
    host_wr(1, 8'hD1, 1);
    chk("R3 R5 D1 absorbed", {7'd0, o_vld}, 8'd0);
    host_wr(0, 8'hDF, 1);
    chk("R6 set absorbed", {7'd0, o_vld}, 8'd0);
    chk("R6 set a20", {7'd0, o_a20}, 8'd1);
    host_wr(1, 8'hFF, 1);
    chk("R8 tail FF absorbed", {7'd0, o_vld}, 8'd0);
    host_wr(1, 8'hD1, 1);
    host_wr(0, 8'hDD, 1);
    chk("R6 clear a20", {7'd0, o_a20}, 8'd0);
    chk("R6 clear absorbed", {7'd0, o_vld}, 8'd0);
  endtask

  task automatic t_bit_only();
    host_wr(1, 8'hD1, 1);
    host_wr(0, 8'h02, 1);
    chk("R6 only bit1 02h", {7'd0, o_a20}, 8'd1);
    host_wr(1, 8'hD1, 1);
    host_wr(0, 8'hFD, 1);
    chk("R6 only bit1 FDh", {7'd0, o_a20}, 8'd0);
  endtask

  task automatic t_double();
    host_wr(1, 8'hD1, 1);
    chk("R7 first D1", {7'd0, o_vld}, 8'd0);
    host_wr(1, 8'hD1, 1);
    chk("R7 second D1", {7'd0, o_vld}, 8'd0);
    host_wr(0, 8'hDF, 1);
    chk("R7 data absorbed", {7'd0, o_vld}, 8'd0);
    chk("R7 a20 set", {7'd0, o_a20}, 8'd1);
  endtask

  task automatic t_cancel();
    host_wr(1, 8'hD1, 1);
    host_wr(1, 8'h55, 1);
    chk("R9 other cmd delivered", {7'd0, o_vld}, 8'd1);
    chk("R9 other cmd byte", o_data, 8'h55);
    host_wr(0, 8'hDD, 1);
    chk("R9 data delivered", {7'd0, o_vld}, 8'd1);
    chk("R9 a20 unchanged", {7'd0, o_a20}, 8'd1);
  endtask

  task automatic t_ff_and_stray();
    host_wr(1, 8'hFF, 1);
    chk("R8 idle FF delivered", {7'd0, o_vld}, 8'd1);
    chk("R8 idle FF byte", o_data, 8'hFF);
    host_wr(1, 8'hD1, 1);
    host_wr(0, 8'hDD, 1);
    host_wr(0, 8'h02, 1);
    chk("R10 stray data delivered", {7'd0, o_vld}, 8'd1);
    chk("R10 stray a20 kept", {7'd0, o_a20}, 8'd0);
  endtask

  task automatic t_rereset();
    do_reset();
    chk("R1 a20 after reset", {7'd0, a20}, 8'd0);
    host_wr(1, 8'hD1, 1);
    chk("R3 enable cleared by reset", {7'd0, o_vld}, 8'd1);
  endtask

  initial begin
    rst_n = 0; en_req = 0; wr_n = 1; cs_n = 1; a0 = 0; data = 0;
    t_reset();
    t_disabled();
    t_nocs();
    t_set_clear();
    t_bit_only();
    t_double();
    t_cancel();
    t_ff_and_stray();
    t_rereset();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule